// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Bit Sampler

This block drives the bit clock of one or two pulse-density-modulation microphones and recovers their one-bit data streams. It derives that clock from a fast IO clock by an integer divisor. Both microphones share a single data pin: one drives it while the clock is high, the other while it is low. The block samples the pin once in each clock phase. It applies per-microphone inversion and gating, and hands one left and one right bit to a downstream decimator with a strobe once per microphone clock period.

The divider field is programmed as the divisor minus two, so the smallest legal divisor is two. The clock starts each period high. It stays high for floor(D/2) IO cycles of the D-cycle period, so odd divisors give a duty cycle just under half. Software can send a single right-side microphone through the left path by flipping the edge select. Channel A is then sampled in the low phase instead of the high phase.

The control block steps through three named states. `PH_IDLE` is held while soft reset is high. `PH_HIGH` covers the high phase and `PH_LOW` the low phase. The transitions are: release of soft reset (`PH_IDLE`→`PH_HIGH`), the end of the high phase at count floor(D/2)-1 (`PH_HIGH`→`PH_LOW`), and the period wrap at count D-1 (`PH_LOW`→`PH_HIGH`). Soft reset returns any state to `PH_IDLE`. The output stage uses three states. `CAP_IDLE` is the stopped state. `CAP_ARMED` waits for the last sample point of the period. `CAP_EMIT` is the one cycle in which the new pair is presented. The output stage moves `CAP_IDLE`→`CAP_ARMED` when the clock runs, `CAP_ARMED`→`CAP_EMIT` at the late sample point, and `CAP_EMIT`→`CAP_ARMED` one cycle later. The divider, skew, edge select, enables and polarities are taken in at the start of every period, and while the block is stopped.

Top module: `pdm_clk_sampler`

## Requirements
- R1: The microphone clock period is D = div_field + 2 IO-clock cycles.
- R2: Within each period the clock is high for the first floor(D/2) cycles and low for the rest. The first cycle after soft reset is released is high.
- R3: With edge_sel = 0, channel A is sampled at the rising-edge sample point and channel B at the falling-edge sample point. With edge_sel = 1 the two swap.
- R4: Each sample point lies s cycles after its edge, where s = min(skew, floor(D/2) - 1). The rising point is at period count s and the falling point is at count floor(D/2) + s.
- R5: A set polarity bit inverts that channel's sampled bit before output.
- R6: A channel whose enable is 0 outputs 0. With both enables 0, no valid strobe is produced.
- R7: sample_valid is high for exactly one cycle per period, at period count (floor(D/2) + s + 2) mod D counted from the period in which the falling point fell. left_bit and right_bit carry that period's pair while it is high.
- R8: One cycle after soft reset is asserted (and during reset), the clock, sample_valid, left_bit and right_bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast IO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous stop; holds the clock and capture idle |
| div_field | input | DIV_W | Divisor minus two |
| edge_sel | input | 1 | 0: A on rising point, 1: A on falling point |
| skew | input | SKEW_W | Sample delay after each edge, in IO cycles |
| en_a | input | 1 | Enable channel A |
| en_b | input | 1 | Enable channel B |
| pol_a | input | 1 | Invert channel A |
| pol_b | input | 1 | Invert channel B |
| pdm_din | input | 1 | Shared microphone data pin |
| pdm_clk_o | output | 1 | Microphone clock |
| left_bit | output | 1 | Channel A sample |
| right_bit | output | 1 | Channel B sample |
| sample_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
A period counter that skips or repeats a value shows up at once on pdm_clk_o: the high or low run length is wrong within the same period. A wrong sample point, edge swap or polarity stays hidden until the next strobe, at most two periods later. It then appears as a left or right bit that differs from the data bit driven in the intended cycle. Each IO cycle carries random data, so a one-cycle error in the sample position is almost always visible. A stray or missing strobe is caught in the cycle where it should or should not occur.

// File: rtl/pdm_clk_pkg.sv
package pdm_clk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } pdm_phase_e;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_EMIT  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic edge_sel;
        logic en_a;
        logic en_b;
        logic pol_a;
        logic pol_b;
    } mic_flags_t;

endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen
    import pdm_clk_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SKEW_W = 4,
    localparam int CW    = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DIV_W-1:0]  div_field,
    input  logic [SKEW_W-1:0] skew_in,
    input  mic_flags_t        flags_in,
    output pdm_phase_e        phase,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     half,
    output logic [SKEW_W-1:0] skew_l,
    output mic_flags_t        flags_l,
    output logic              pdm_clk
);

    pdm_phase_e        phase_q, phase_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [DIV_W-1:0]  div_l;
    logic [CW-1:0]     divisor;
    logic [CW-1:0]     last_cnt;
    logic              load;
    logic              clk_q;

    // Divider field is stored offset by two.
    assign divisor  = CW'(div_l) + CW'(2);
    assign last_cnt = divisor - CW'(1);
    assign half     = divisor >> 1;

    // Next-state decision.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                load  = 1'b1;
                if (!soft_rst) phase_d = PH_HIGH;
            end
            PH_HIGH: begin
                cnt_d = cnt_q + CW'(1);
                if (cnt_q == half - CW'(1)) phase_d = PH_LOW;
            end
            PH_LOW: begin
                if (cnt_q == last_cnt) begin
                    cnt_d   = '0;
                    phase_d = PH_HIGH;
                    load    = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: phase_d = PH_IDLE;
        endcase
        if (soft_rst) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: settings taken in at period start, registered clock pin.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_l   <= '0;
            skew_l  <= '0;
            flags_l <= '0;
            clk_q   <= 1'b0;
        end else begin
            if (load) begin
                div_l   <= div_field;
                skew_l  <= skew_in;
                flags_l <= flags_in;
            end
            clk_q <= (phase_d == PH_HIGH);
        end
    end

    assign phase   = phase_q;
    assign cnt     = cnt_q;
    assign pdm_clk = clk_q;

    // R2
    high_phase_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH) |-> (cnt_q < half));

    // R1
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < divisor);

    // R1
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOW && cnt_q == last_cnt && !soft_rst)
        |=> (phase_q == PH_HIGH && cnt_q == '0));

    // R8
    stop_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (phase_q == PH_IDLE && !pdm_clk));

endmodule

// File: rtl/pdm_sample_point.sv
module pdm_sample_point #(
    parameter int CW     = 9,
    parameter int SKEW_W = 4
) (
    input  logic [CW-1:0]     half,
    input  logic [SKEW_W-1:0] skew_l,
    input  logic              edge_sel,
    output logic [CW-1:0]     pos_a,
    output logic [CW-1:0]     pos_b,
    output logic [CW-1:0]     pos_late
);

    logic [CW-1:0] skew_ext;
    logic [CW-1:0] skew_eff;
    logic [CW-1:0] pos_rise;
    logic [CW-1:0] pos_fall;

    // Skew is limited so both points stay inside their own phase.
    always_comb begin
        skew_ext = CW'(skew_l);
        skew_eff = (skew_ext >= half) ? (half - CW'(1)) : skew_ext;
        pos_rise = skew_eff;
        pos_fall = half + skew_eff;
        pos_a    = edge_sel ? pos_fall : pos_rise;
        pos_b    = edge_sel ? pos_rise : pos_fall;
        pos_late = pos_fall;
    end

endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
    import pdm_clk_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] pos_a,
    input  logic [CW-1:0] pos_b,
    input  logic [CW-1:0] pos_late,
    input  mic_flags_t    flags,
    input  logic          din,
    output logic          left_bit,
    output logic          right_bit,
    output logic          sample_valid
);

    cap_state_e st_q, st_d;
    logic       a_q, b_q;
    logic       hit_late;

    assign hit_late = run && (cnt == pos_late) && (flags.en_a || flags.en_b);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_IDLE:  if (run) st_d = CAP_ARMED;
            CAP_ARMED: if (hit_late) st_d = CAP_EMIT;
            CAP_EMIT:  st_d = CAP_ARMED;
            default:   st_d = CAP_IDLE;
        endcase
        if (soft_rst) st_d = CAP_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAP_IDLE;
        else        st_q <= st_d;
    end

    // Sample holders and output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q          <= 1'b0;
            b_q          <= 1'b0;
            left_bit     <= 1'b0;
            right_bit    <= 1'b0;
            sample_valid <= 1'b0;
        end else if (soft_rst) begin
            a_q          <= 1'b0;
            b_q          <= 1'b0;
            left_bit     <= 1'b0;
            right_bit    <= 1'b0;
            sample_valid <= 1'b0;
        end else begin
            if (run && cnt == pos_a) a_q <= flags.en_a & (din ^ flags.pol_a);
            if (run && cnt == pos_b) b_q <= flags.en_b & (din ^ flags.pol_b);
            sample_valid <= (st_q == CAP_EMIT);
            if (st_q == CAP_EMIT) begin
                left_bit  <= a_q;
                right_bit <= b_q;
            end
        end
    end

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R8
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!sample_valid && !left_bit && !right_bit));

    // R7
    emit_follows_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_EMIT) |-> $past(hit_late));

endmodule

// File: rtl/pdm_clk_sampler.sv
module pdm_clk_sampler
    import pdm_clk_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SKEW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [DIV_W-1:0]  div_field,
    input  logic              edge_sel,
    input  logic [SKEW_W-1:0] skew,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              pol_a,
    input  logic              pol_b,
    input  logic              pdm_din,
    output logic              pdm_clk_o,
    output logic              left_bit,
    output logic              right_bit,
    output logic              sample_valid
);

    localparam int CW = DIV_W + 1;

    mic_flags_t        flags_in;
    mic_flags_t        flags_l;
    pdm_phase_e        phase;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     half;
    logic [SKEW_W-1:0] skew_l;
    logic [CW-1:0]     pos_a, pos_b, pos_late;

    assign flags_in = '{edge_sel: edge_sel, en_a: en_a, en_b: en_b,
                        pol_a: pol_a, pol_b: pol_b};

    pdm_clk_gen #(.DIV_W(DIV_W), .SKEW_W(SKEW_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .div_field(div_field),
        .skew_in  (skew),
        .flags_in (flags_in),
        .phase    (phase),
        .cnt      (cnt),
        .half     (half),
        .skew_l   (skew_l),
        .flags_l  (flags_l),
        .pdm_clk  (pdm_clk_o)
    );

    pdm_sample_point #(.CW(CW), .SKEW_W(SKEW_W)) u_pts (
        .half    (half),
        .skew_l  (skew_l),
        .edge_sel(flags_l.edge_sel),
        .pos_a   (pos_a),
        .pos_b   (pos_b),
        .pos_late(pos_late)
    );

    pdm_capture #(.CW(CW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .run         (phase != PH_IDLE),
        .cnt         (cnt),
        .pos_a       (pos_a),
        .pos_b       (pos_b),
        .pos_late    (pos_late),
        .flags       (flags_l),
        .din         (pdm_din),
        .left_bit    (left_bit),
        .right_bit   (right_bit),
        .sample_valid(sample_valid)
    );

endmodule

// File: tb/test_pdm_clk_sampler.sv
module test_pdm_clk_sampler;
    localparam int DIV_W  = 8;
    localparam int SKEW_W = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, soft_rst, edge_sel, en_a, en_b, pol_a, pol_b, pdm_din;
    logic [DIV_W-1:0]  div_field;
    logic [SKEW_W-1:0] skew;
    logic              pdm_clk_o, left_bit, right_bit, sample_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit fin   = 1'b0;
    bit pat [4096];

    pdm_clk_sampler #(.DIV_W(DIV_W), .SKEW_W(SKEW_W)) i_pdm_clk_sampler (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div_field(div_field),
        .edge_sel(edge_sel), .skew(skew), .en_a(en_a), .en_b(en_b),
        .pol_a(pol_a), .pol_b(pol_b), .pdm_din(pdm_din),
        .pdm_clk_o(pdm_clk_o), .left_bit(left_bit), .right_bit(right_bit),
        .sample_valid(sample_valid)
    );

    task automatic chk(string req, string what, logic act, logic expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic int eff_skew(int d, int s);
        int h = d / 2;
        return (s > h - 1) ? h - 1 : s;
    endfunction

    task automatic run_cfg(int dv, int sk, bit es, bit ea, bit eb, bit pa, bit pb, int periods);
        int d    = dv + 2;
        int h    = d / 2;
        int s    = eff_skew(d, sk);
        int prs  = s;
        int pfl  = h + s;
        int posa = es ? pfl : prs;
        int posb = es ? prs : pfl;
        int ncyc = d * periods + 4;
        // R8: stop, then outputs must be quiet one cycle later
        @(negedge clk);
        soft_rst = 1'b1;
        div_field = DIV_W'(dv); skew = SKEW_W'(sk); edge_sel = es;
        en_a = ea; en_b = eb; pol_a = pa; pol_b = pb;
        @(negedge clk);
        chk("R8", "clk", pdm_clk_o, 1'b0);
        chk("R8", "valid", sample_valid, 1'b0);
        chk("R8", "left", left_bit, 1'b0);
        chk("R8", "right", right_bit, 1'b0);
        for (int i = 0; i < ncyc; i++) pat[i] = 1'($urandom);
        @(negedge clk);
        soft_rst = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            begin
                bit ev;
                chk("R1,R2", "clk", pdm_clk_o, ((k % d) < h));
                ev = (ea || eb) && k >= 2 && (((k - 2) % d) == pfl);
                chk("R6,R7", "valid", sample_valid, ev);
                if (ev) begin
                    int p = (k - 2) / d;
                    bit xl = ea ? (pat[p * d + posa] ^ pa) : 1'b0;
                    bit xr = eb ? (pat[p * d + posb] ^ pb) : 1'b0;
                    chk("R3,R4,R5,R6", "left", left_bit, xl);
                    chk("R3,R4,R5,R6", "right", right_bit, xr);
                end
            end
            pdm_din = pat[k];
        end
    endtask

    initial begin
        rst_n = 1'b0; soft_rst = 1'b1; div_field = '0; skew = '0;
        edge_sel = 1'b0; en_a = 1'b0; en_b = 1'b0; pol_a = 1'b0; pol_b = 1'b0;
        pdm_din = 1'b0;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "reset clk", pdm_clk_o, 1'b0);
        chk("R8", "reset valid", sample_valid, 1'b0);
        chk("R8", "reset left", left_bit, 1'b0);
        chk("R8", "reset right", right_bit, 1'b0);
        rst_n = 1'b1;
        // Directed corners: minimum divisor, odd divisor, large divisor,
        // clamped skew, swapped edge, no channel enabled, polarity.
        run_cfg(0, 15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8);
        run_cfg(1, 0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8);
        run_cfg(255, 3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3);
        run_cfg(10, 15, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6);
        run_cfg(5, 2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6);
        run_cfg(7, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6);
        for (int r = 0; r < 24; r++) begin
            run_cfg(int'($urandom_range(0, 13)), int'($urandom_range(0, 15)),
                    1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 6);
        end
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule